// File: doc/BRIEF.md
# Multi-Slot Circular Buffer Pointer Manager

This block keeps the bookkeeping for up to 64 independent ring buffers that live in a shared local memory. Producer cores use it to hand pages to consumer cores. It never moves the data. It keeps each buffer's region, its page geometry, its read, write and tile-write addresses, and a pair of 16-bit page counters. From these it tells each side how many pages it may write or read.

A slot is set up with four 32-bit configuration words, and writing the last word starts the slot. A producer asks whether a given number of pages is free and then pushes them. A consumer asks whether a given number of pages is available and then pops them. A per-slot enable mask gates both sides. A query port returns one slot's state. Addresses and sizes come back either in bytes, for data-movement clients, or in 16-byte units, for compute clients.

Top module: `cbm_ptr_mgr`

## Requirements
- R1: There are 64 slots, each chosen by a 6-bit index. A configuration write selects its word with `cfg_word`: 0 is the start address in bytes, 1 the total size in bytes, 2 the page count, and 3 the page size in bytes. Writing word 3 starts the slot. Its limit becomes start plus size, its read, write and tile pointers are set to the start address, and both page counters are cleared.
- R2: An accepted push of N pages adds N times the page size to the write pointer. If the result is at or beyond the limit, the total size is subtracted from it. An accepted pop moves the read pointer in the same way.
- R3: Each slot has a 16-bit received counter and a 16-bit acknowledged counter. Available pages equal received minus acknowledged, modulo 2^16. Free pages equal the low 16 bits of the page count minus available pages.
- R4: `prod_ready` is high exactly when the producer's slot is enabled and has at least `prod_npages` free pages. `cons_ready` is high exactly when the consumer's slot is enabled and has at least `cons_npages` available pages.
- R5: A push larger than the free count, or a pop larger than the available count, on an enabled slot changes no state. It raises `prod_err` or `cons_err` for one cycle, on the cycle after the request.
- R6: A push and a pop on the same slot in the same cycle are both applied. The counters and pointers then reflect both.
- R7: The 64-bit enable mask is written 32 bits at a time. `en_sel` = 0 writes slots 0 to 31 and `en_sel` = 1 writes slots 32 to 63, with bit k of the word belonging to slot k or slot 32+k. The mask resets to zero. On a disabled slot, pushes, pops and tile advances have no effect and raise no error. `q_en` shows the queried slot's mask bit.
- R8: A `tile_adv` strobe moves the producer slot's tile pointer forward by one page, with the same wrap rule as R2. The tile pointer is independent of the write pointer.
- R9: With `q_unit16` = 1, the query's read, write and tile addresses, its size and its page size are the byte values shifted right by 4. With `q_unit16` = 0 they are the byte values.
- R10: Reset is asynchronous and active low, and is released after two clock edges. While in reset, every slot field, the mask and both error flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_slot | input | 6 | Slot being configured |
| cfg_word | input | 2 | Word select (0 start, 1 size, 2 pages, 3 page size) |
| cfg_wdata | input | 32 | Configuration word value |
| en_we | input | 1 | Enable mask write strobe |
| en_sel | input | 1 | Mask half select (0 low slots, 1 high slots) |
| en_wdata | input | 32 | Mask half value |
| prod_slot | input | 6 | Producer slot |
| prod_npages | input | 16 | Pages to reserve or push |
| prod_push | input | 1 | Push request |
| tile_adv | input | 1 | Advance the producer slot's tile pointer by one page |
| prod_ready | output | 1 | Producer slot has room for prod_npages |
| prod_err | output | 1 | Previous push overflowed |
| cons_slot | input | 6 | Consumer slot |
| cons_npages | input | 16 | Pages to wait for or pop |
| cons_pop | input | 1 | Pop request |
| cons_ready | output | 1 | Consumer slot holds at least cons_npages |
| cons_err | output | 1 | Previous pop underflowed |
| q_slot | input | 6 | Slot to query |
| q_unit16 | input | 1 | 1 returns 16-byte units, 0 returns bytes |
| q_en | output | 1 | Enable bit of the queried slot |
| q_free | output | 16 | Free pages of the queried slot |
| q_avail | output | 16 | Available pages of the queried slot |
| q_rd_addr | output | 32 | Read pointer |
| q_wr_addr | output | 32 | Write pointer |
| q_tile_addr | output | 32 | Tile write pointer |
| q_size | output | 32 | Total size |
| q_page_size | output | 32 | Page size |

## Verification
The bench drives multi-page pushes and pops whose pointer sum lands exactly on the limit or past it. A design that compares with greater-than instead of greater-or-equal would leave a pointer sitting at the limit. The bench also pushes past the 16-bit counter range, where an available count taken from wide counters or without modular subtraction would come out wrong. Overflowing pushes and underflowing pops must leave the counts unchanged. A simultaneous push and pop on one slot must show both effects, so a design that lets one side win would lose a page. The bench further checks that traffic to a disabled slot has no effect, that the tile pointer is independent of the write pointer, and that rewriting the last configuration word restarts a slot that already holds pages.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int unsigned CBM_ADDR_W = 32;
  localparam int unsigned CBM_CNT_W  = 16;
  localparam int unsigned CBM_MASK_W = 32;

  typedef enum logic [1:0] {
    CFG_BASE   = 2'd0,
    CFG_SIZE   = 2'd1,
    CFG_NPAGES = 2'd2,
    CFG_PSIZE  = 2'd3
  } cfg_word_e;

  typedef struct packed {
    logic [CBM_ADDR_W-1:0] base;
    logic [CBM_ADDR_W-1:0] size;
    logic [CBM_ADDR_W-1:0] limit;
    logic [CBM_ADDR_W-1:0] npages;
    logic [CBM_ADDR_W-1:0] psize;
    logic [CBM_ADDR_W-1:0] rd;
    logic [CBM_ADDR_W-1:0] wr;
    logic [CBM_ADDR_W-1:0] twr;
    logic [CBM_CNT_W-1:0]  recv;
    logic [CBM_CNT_W-1:0]  ack;
  } slot_t;
endpackage

// File: rtl/cbm_rst_sync.sv
module cbm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_ns  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_ns  <= stage_q;
    end
  end
endmodule

// File: rtl/cbm_wrap_adv.sv
module cbm_wrap_adv #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] ptr,
  input  logic [W-1:0] step,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] size,
  output logic [W-1:0] nxt
);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, ptr} + {1'b0, step};
    if (sum >= {1'b0, limit}) begin
      nxt = W'(sum - {1'b0, size});
    end else begin
      nxt = sum[W-1:0];
    end
  end
endmodule

// File: rtl/cbm_unit_view.sv
module cbm_unit_view #(
  parameter int unsigned W     = 32,
  parameter int unsigned SHIFT = 4
) (
  input  logic         unit16,
  input  logic [W-1:0] val,
  output logic [W-1:0] view
);
  always_comb begin
    if (unit16) begin
      view = val >> SHIFT;
    end else begin
      view = val;
    end
  end
endmodule

// File: rtl/cbm_ptr_mgr.sv
module cbm_ptr_mgr #(
  parameter int unsigned NUM_SLOTS  = 64,
  parameter int unsigned UNIT_SHIFT = 4,
  localparam int unsigned ADDR_W    = cbm_pkg::CBM_ADDR_W,
  localparam int unsigned CNT_W     = cbm_pkg::CBM_CNT_W,
  localparam int unsigned MASK_W    = cbm_pkg::CBM_MASK_W,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  localparam int unsigned MASK_WORDS = NUM_SLOTS / MASK_W,
  localparam int unsigned MSEL_W    = (MASK_WORDS > 1) ? $clog2(MASK_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [1:0]        cfg_word,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              en_we,
  input  logic [MSEL_W-1:0] en_sel,
  input  logic [MASK_W-1:0] en_wdata,
  input  logic [SLOT_W-1:0] prod_slot,
  input  logic [CNT_W-1:0]  prod_npages,
  input  logic              prod_push,
  input  logic              tile_adv,
  output logic              prod_ready,
  output logic              prod_err,
  input  logic [SLOT_W-1:0] cons_slot,
  input  logic [CNT_W-1:0]  cons_npages,
  input  logic              cons_pop,
  output logic              cons_ready,
  output logic              cons_err,
  input  logic [SLOT_W-1:0] q_slot,
  input  logic              q_unit16,
  output logic              q_en,
  output logic [CNT_W-1:0]  q_free,
  output logic [CNT_W-1:0]  q_avail,
  output logic [ADDR_W-1:0] q_rd_addr,
  output logic [ADDR_W-1:0] q_wr_addr,
  output logic [ADDR_W-1:0] q_tile_addr,
  output logic [ADDR_W-1:0] q_size,
  output logic [ADDR_W-1:0] q_page_size
);
  import cbm_pkg::*;

  localparam int unsigned NUM_VIEWS = 5;
  localparam int unsigned MUL_W     = ADDR_W + CNT_W;

  logic rst_ns;

  slot_t                 slot_q [NUM_SLOTS];
  slot_t                 slot_d [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]  slot_ce;
  logic [NUM_SLOTS-1:0]  mask_q;
  logic [NUM_SLOTS-1:0]  mask_d;
  logic                  mask_ce;

  slot_t                 prod_cur;
  slot_t                 cons_cur;
  slot_t                 q_cur;
  logic [CNT_W-1:0]      prod_avail;
  logic [CNT_W-1:0]      prod_free;
  logic [CNT_W-1:0]      cons_avail;
  logic                  prod_fit;
  logic                  cons_fit;
  logic                  prod_cfg_hit;
  logic                  cons_cfg_hit;
  logic                  push_go;
  logic                  pop_go;
  logic                  tile_go;
  logic                  prod_err_d;
  logic                  cons_err_d;
  logic [MUL_W-1:0]      prod_mul;
  logic [MUL_W-1:0]      cons_mul;
  logic [ADDR_W-1:0]     wr_nxt;
  logic [ADDR_W-1:0]     rd_nxt;
  logic [ADDR_W-1:0]     twr_nxt;
  logic [ADDR_W-1:0]     view_in  [NUM_VIEWS];
  logic [ADDR_W-1:0]     view_out [NUM_VIEWS];

  cbm_rst_sync rst_sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  // Selected-slot views and acceptance decisions
  always_comb begin
    prod_cur     = slot_q[prod_slot];
    cons_cur     = slot_q[cons_slot];
    prod_avail   = prod_cur.recv - prod_cur.ack;
    prod_free    = prod_cur.npages[CNT_W-1:0] - prod_avail;
    cons_avail   = cons_cur.recv - cons_cur.ack;
    prod_fit     = (prod_npages <= prod_free);
    cons_fit     = (cons_npages <= cons_avail);
    prod_ready   = mask_q[prod_slot] & prod_fit;
    cons_ready   = mask_q[cons_slot] & cons_fit;
    prod_cfg_hit = cfg_we && (cfg_slot == prod_slot);
    cons_cfg_hit = cfg_we && (cfg_slot == cons_slot);
    push_go      = prod_push && prod_ready && !prod_cfg_hit;
    pop_go       = cons_pop && cons_ready && !cons_cfg_hit;
    tile_go      = tile_adv && mask_q[prod_slot] && !prod_cfg_hit;
    prod_err_d   = prod_push && mask_q[prod_slot] && !prod_fit && !prod_cfg_hit;
    cons_err_d   = cons_pop && mask_q[cons_slot] && !cons_fit && !cons_cfg_hit;
    prod_mul     = {{ADDR_W{1'b0}}, prod_npages} * {{CNT_W{1'b0}}, prod_cur.psize};
    cons_mul     = {{ADDR_W{1'b0}}, cons_npages} * {{CNT_W{1'b0}}, cons_cur.psize};
  end

  cbm_wrap_adv #(.W(ADDR_W)) wr_adv_i (
    .ptr   (prod_cur.wr),
    .step  (prod_mul[ADDR_W-1:0]),
    .limit (prod_cur.limit),
    .size  (prod_cur.size),
    .nxt   (wr_nxt)
  );

  cbm_wrap_adv #(.W(ADDR_W)) twr_adv_i (
    .ptr   (prod_cur.twr),
    .step  (prod_cur.psize),
    .limit (prod_cur.limit),
    .size  (prod_cur.size),
    .nxt   (twr_nxt)
  );

  cbm_wrap_adv #(.W(ADDR_W)) rd_adv_i (
    .ptr   (cons_cur.rd),
    .step  (cons_mul[ADDR_W-1:0]),
    .limit (cons_cur.limit),
    .size  (cons_cur.size),
    .nxt   (rd_nxt)
  );

  // Slot next-state: a configuration write outranks traffic on the same slot
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      slot_d[i]  = slot_q[i];
      slot_ce[i] = 1'b0;
      if (cfg_we && (cfg_slot == SLOT_W'(i))) begin
        slot_ce[i] = 1'b1;
        case (cfg_word_e'(cfg_word))
          CFG_BASE:   slot_d[i].base   = cfg_wdata;
          CFG_SIZE:   slot_d[i].size   = cfg_wdata;
          CFG_NPAGES: slot_d[i].npages = cfg_wdata;
          default: begin
            slot_d[i].psize = cfg_wdata;
            slot_d[i].limit = slot_q[i].base + slot_q[i].size;
            slot_d[i].rd    = slot_q[i].base;
            slot_d[i].wr    = slot_q[i].base;
            slot_d[i].twr   = slot_q[i].base;
            slot_d[i].recv  = '0;
            slot_d[i].ack   = '0;
          end
        endcase
      end else begin
        if (push_go && (prod_slot == SLOT_W'(i))) begin
          slot_ce[i]     = 1'b1;
          slot_d[i].recv = slot_q[i].recv + prod_npages;
          slot_d[i].wr   = wr_nxt;
        end
        if (tile_go && (prod_slot == SLOT_W'(i))) begin
          slot_ce[i]    = 1'b1;
          slot_d[i].twr = twr_nxt;
        end
        if (pop_go && (cons_slot == SLOT_W'(i))) begin
          slot_ce[i]    = 1'b1;
          slot_d[i].ack = slot_q[i].ack + cons_npages;
          slot_d[i].rd  = rd_nxt;
        end
      end
    end
  end

  // Enable mask next-state, one 32-bit half per write
  always_comb begin
    mask_d  = mask_q;
    mask_ce = en_we;
    for (int w = 0; w < MASK_WORDS; w++) begin
      if (en_we && (en_sel == MSEL_W'(w))) begin
        mask_d[w*MASK_W +: MASK_W] = en_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slot_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (slot_ce[i]) begin
          slot_q[i] <= slot_d[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mask_q <= '0;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      prod_err <= 1'b0;
      cons_err <= 1'b0;
    end else begin
      prod_err <= prod_err_d;
      cons_err <= cons_err_d;
    end
  end

  // Query port
  always_comb begin
    q_cur       = slot_q[q_slot];
    q_en        = mask_q[q_slot];
    q_avail     = q_cur.recv - q_cur.ack;
    q_free      = q_cur.npages[CNT_W-1:0] - q_avail;
    view_in[0]  = q_cur.rd;
    view_in[1]  = q_cur.wr;
    view_in[2]  = q_cur.twr;
    view_in[3]  = q_cur.size;
    view_in[4]  = q_cur.psize;
    q_rd_addr   = view_out[0];
    q_wr_addr   = view_out[1];
    q_tile_addr = view_out[2];
    q_size      = view_out[3];
    q_page_size = view_out[4];
  end

  for (genvar f = 0; f < NUM_VIEWS; f++) begin : g_view
    cbm_unit_view #(.W(ADDR_W), .SHIFT(UNIT_SHIFT)) view_i (
      .unit16 (q_unit16),
      .val    (view_in[f]),
      .view   (view_out[f])
    );
  end
endmodule

// File: rtl/cbm_ptr_mgr_chk.sv
module cbm_ptr_mgr_chk #(
  parameter int unsigned NUM_SLOTS = 64,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W    = cbm_pkg::CBM_CNT_W
) (
  input logic               clk,
  input logic               rst_ns,
  input logic               cfg_we,
  input logic [SLOT_W-1:0]  cfg_slot,
  input logic [1:0]         cfg_word,
  input logic [SLOT_W-1:0]  prod_slot,
  input logic [CNT_W-1:0]   prod_npages,
  input logic               prod_push,
  input logic               prod_ready,
  input logic               prod_err,
  input logic [SLOT_W-1:0]  cons_slot,
  input logic               cons_pop,
  input logic               cons_ready,
  input logic               cons_err,
  input cbm_pkg::slot_t     slot_q [NUM_SLOTS]
);
  // R5
  prod_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    prod_err |-> $past(prod_push && !prod_ready));

  // R5
  cons_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cons_err |-> $past(cons_pop && !cons_ready));

  // R3
  recv_count_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (prod_push && prod_ready && !(cfg_we && cfg_slot == prod_slot))
    |=> slot_q[$past(prod_slot)].recv == CNT_W'($past(slot_q[prod_slot].recv) + $past(prod_npages)));

  // R2
  wr_in_region_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (prod_push && prod_ready && prod_npages != '0 && !(cfg_we && cfg_slot == prod_slot))
    |=> (slot_q[$past(prod_slot)].wr < slot_q[$past(prod_slot)].limit)
        && (slot_q[$past(prod_slot)].wr >= slot_q[$past(prod_slot)].base));

  // R1
  cfg_start_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cfg_we && cfg_word == 2'd3)
    |=> (slot_q[$past(cfg_slot)].rd == slot_q[$past(cfg_slot)].base)
        && (slot_q[$past(cfg_slot)].recv == '0) && (slot_q[$past(cfg_slot)].ack == '0));
endmodule

bind cbm_ptr_mgr cbm_ptr_mgr_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk         (clk),
  .rst_ns      (rst_ns),
  .cfg_we      (cfg_we),
  .cfg_slot    (cfg_slot),
  .cfg_word    (cfg_word),
  .prod_slot   (prod_slot),
  .prod_npages (prod_npages),
  .prod_push   (prod_push),
  .prod_ready  (prod_ready),
  .prod_err    (prod_err),
  .cons_slot   (cons_slot),
  .cons_pop    (cons_pop),
  .cons_ready  (cons_ready),
  .cons_err    (cons_err),
  .slot_q      (slot_q)
);

// File: tb/cbm_ptr_mgr_tb_top.sv
module cbm_ptr_mgr_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_slot;
  logic [1:0]  cfg_word;
  logic [31:0] cfg_wdata;
  logic        en_we;
  logic [0:0]  en_sel;
  logic [31:0] en_wdata;
  logic [5:0]  prod_slot;
  logic [15:0] prod_npages;
  logic        prod_push;
  logic        tile_adv;
  logic        prod_ready;
  logic        prod_err;
  logic [5:0]  cons_slot;
  logic [15:0] cons_npages;
  logic        cons_pop;
  logic        cons_ready;
  logic        cons_err;
  logic [5:0]  q_slot;
  logic        q_unit16;
  logic        q_en;
  logic [15:0] q_free;
  logic [15:0] q_avail;
  logic [31:0] q_rd_addr;
  logic [31:0] q_wr_addr;
  logic [31:0] q_tile_addr;
  logic [31:0] q_size;
  logic [31:0] q_page_size;

  int n_chk;
  int n_fail;

  cbm_ptr_mgr dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .en_we(en_we), .en_sel(en_sel), .en_wdata(en_wdata),
    .prod_slot(prod_slot), .prod_npages(prod_npages), .prod_push(prod_push),
    .tile_adv(tile_adv), .prod_ready(prod_ready), .prod_err(prod_err),
    .cons_slot(cons_slot), .cons_npages(cons_npages), .cons_pop(cons_pop),
    .cons_ready(cons_ready), .cons_err(cons_err),
    .q_slot(q_slot), .q_unit16(q_unit16), .q_en(q_en), .q_free(q_free),
    .q_avail(q_avail), .q_rd_addr(q_rd_addr), .q_wr_addr(q_wr_addr),
    .q_tile_addr(q_tile_addr), .q_size(q_size), .q_page_size(q_page_size)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  kind;   // 0 push, 1 pop, 2 push and pop together
    logic [15:0] n;
    logic [15:0] free;
    logic [15:0] avail;
    logic [31:0] wr;
    logic [31:0] rd;
  } vec_t;

  // Slot 5: start 0x1000, size 0x400, 4 pages of 0x100
  localparam vec_t VEC [0:7] = '{
    '{2'd0, 16'd1, 16'd3, 16'd1, 32'h1100, 32'h1000},
    '{2'd0, 16'd2, 16'd1, 16'd3, 32'h1300, 32'h1000},
    '{2'd1, 16'd2, 16'd3, 16'd1, 32'h1300, 32'h1200},
    '{2'd0, 16'd3, 16'd0, 16'd4, 32'h1200, 32'h1200},
    '{2'd1, 16'd4, 16'd4, 16'd0, 32'h1200, 32'h1200},
    '{2'd0, 16'd1, 16'd3, 16'd1, 32'h1300, 32'h1200},
    '{2'd2, 16'd1, 16'd3, 16'd1, 32'h1000, 32'h1300},
    '{2'd0, 16'd3, 16'd0, 16'd4, 32'h1300, 32'h1300}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] s, input logic [1:0] w, input logic [31:0] d);
    cfg_we = 1'b1; cfg_slot = s; cfg_word = w; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_all(input logic [5:0] s, input logic [31:0] b, input logic [31:0] sz,
                         input logic [31:0] np, input logic [31:0] ps);
    cfg_write(s, 2'd0, b);
    cfg_write(s, 2'd1, sz);
    cfg_write(s, 2'd2, np);
    cfg_write(s, 2'd3, ps);
  endtask

  task automatic en_write(input logic sel, input logic [31:0] d);
    en_we = 1'b1; en_sel = sel; en_wdata = d;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic traffic(input logic [1:0] kind, input logic [5:0] s, input logic [15:0] n);
    prod_slot = s; cons_slot = s; prod_npages = n; cons_npages = n;
    prod_push = (kind == 2'd0) || (kind == 2'd2);
    cons_pop  = (kind == 2'd1) || (kind == 2'd2);
    @(negedge clk);
    prod_push = 1'b0; cons_pop = 1'b0;
  endtask

  task automatic look(input logic [5:0] s, input logic u);
    q_slot = s; q_unit16 = u;
    #0.5;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_slot = '0; cfg_word = '0; cfg_wdata = '0;
    en_we = 1'b0; en_sel = '0; en_wdata = '0;
    prod_slot = '0; prod_npages = '0; prod_push = 1'b0; tile_adv = 1'b0;
    cons_slot = '0; cons_npages = '0; cons_pop = 1'b0; q_slot = '0; q_unit16 = 1'b0;
    repeat (4) @(negedge clk);

    // R10 reset state
    look(6'd5, 1'b0);
    chk("R10", "free", 32'(q_free), 32'd0);
    chk("R10", "wr", q_wr_addr, 32'd0);
    chk("R10", "en", 32'(q_en), 32'd0);
    chk("R10", "prod_err", 32'(prod_err), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    en_write(1'b0, 32'h0000_0020);
    cfg_all(6'd5, 32'h1000, 32'h400, 32'd4, 32'h100);
    look(6'd5, 1'b0);
    chk("R1", "start wr", q_wr_addr, 32'h1000);
    chk("R1", "start free", 32'(q_free), 32'd4);

    // Vector table: R2, R3, R6 on slot 5
    for (int v = 0; v < 8; v++) begin
      traffic(VEC[v].kind, 6'd5, VEC[v].n);
      look(6'd5, 1'b0);
      chk((VEC[v].kind == 2'd2) ? "R6" : "R3", "free", 32'(q_free), 32'(VEC[v].free));
      chk((VEC[v].kind == 2'd2) ? "R6" : "R3", "avail", 32'(q_avail), 32'(VEC[v].avail));
      chk("R2", "wr", q_wr_addr, VEC[v].wr);
      chk("R2", "rd", q_rd_addr, VEC[v].rd);
    end

    // R4 ready flags, slot 5 full with 4 pages
    prod_slot = 6'd5; prod_npages = 16'd1; cons_slot = 6'd5; cons_npages = 16'd4;
    #0.5;
    chk("R4", "prod_ready full", 32'(prod_ready), 32'd0);
    chk("R4", "cons_ready 4", 32'(cons_ready), 32'd1);
    cons_npages = 16'd5;
    #0.5;
    chk("R4", "cons_ready 5", 32'(cons_ready), 32'd0);
    @(negedge clk);

    // R5 overflow push
    traffic(2'd0, 6'd5, 16'd1);
    look(6'd5, 1'b0);
    chk("R5", "prod_err", 32'(prod_err), 32'd1);
    chk("R5", "avail kept", 32'(q_avail), 32'd4);
    chk("R5", "wr kept", q_wr_addr, 32'h1300);
    @(negedge clk);
    chk("R5", "prod_err one cycle", 32'(prod_err), 32'd0);

    // R8 tile pointer
    tile_adv = 1'b1; prod_slot = 6'd5;
    repeat (2) @(negedge clk);
    tile_adv = 1'b0;
    look(6'd5, 1'b0);
    chk("R8", "tile", q_tile_addr, 32'h1200);
    chk("R8", "wr untouched", q_wr_addr, 32'h1300);

    // R9 16-byte view
    look(6'd5, 1'b1);
    chk("R9", "wr16", q_wr_addr, 32'h130);
    chk("R9", "size16", q_size, 32'h40);
    chk("R9", "psize16", q_page_size, 32'h10);
    look(6'd5, 1'b0);

    // R7 disabled slot 40 ignores traffic
    cfg_all(6'd40, 32'h2000, 32'h200, 32'd2, 32'h100);
    traffic(2'd0, 6'd40, 16'd1);
    look(6'd40, 1'b0);
    chk("R7", "disabled avail", 32'(q_avail), 32'd0);
    chk("R7", "disabled err", 32'(prod_err), 32'd0);
    chk("R7", "disabled en", 32'(q_en), 32'd0);
    en_write(1'b1, 32'h0000_0100);
    traffic(2'd0, 6'd40, 16'd1);
    look(6'd40, 1'b0);
    chk("R7", "enabled en", 32'(q_en), 32'd1);
    chk("R7", "enabled avail", 32'(q_avail), 32'd1);

    // R5 underflow pop
    traffic(2'd1, 6'd40, 16'd2);
    look(6'd40, 1'b0);
    chk("R5", "cons_err", 32'(cons_err), 32'd1);
    chk("R5", "avail kept pop", 32'(q_avail), 32'd1);

    // R3 counter modulo wrap on slot 7
    en_write(1'b0, 32'h0000_00A0);
    cfg_all(6'd7, 32'h0, 32'hFFFF0, 32'hFFFF, 32'h10);
    traffic(2'd0, 6'd7, 16'hF000);
    traffic(2'd1, 6'd7, 16'hF000);
    traffic(2'd0, 6'd7, 16'h2000);
    look(6'd7, 1'b0);
    chk("R3", "avail wrap", 32'(q_avail), 32'h2000);
    chk("R3", "free wrap", 32'(q_free), 32'hDFFF);
    chk("R2", "wr wrap large", q_wr_addr, 32'h10010);
    chk("R2", "rd large", q_rd_addr, 32'hF0000);

    // R1 reload restarts slot 5
    cfg_write(6'd5, 2'd3, 32'h100);
    look(6'd5, 1'b0);
    chk("R1", "reload avail", 32'(q_avail), 32'd0);
    chk("R1", "reload rd", q_rd_addr, 32'h1000);
    chk("R1", "reload tile", q_tile_addr, 32'h1000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule